// File: doc/BRIEF.md
# Power Module Startup Sequencer

This block is the supervisory controller of a battery power-conversion module. It takes the module from reset through a battery-management handshake, a precharge phase with the main contactor open, and a soft-start ramp into regulated operation. From regulated operation it can step into a reduced-power state, an idle float state or an orderly shutdown. Any fault sends it to a latched fault state with the power stage off.

The power stage and the protection logic are not part of this block. They are represented only by status inputs. Outputs are a master enable for the converter, the contactor command, the state code, a sticky flag for a battery-management timeout and a ramp fraction for the soft-start reference.

All dwell lengths are cycle-count parameters. The production defaults are long, and a test can override them with short values. One shared timer counts the cycles spent in the current state. It restarts at zero on every state change and saturates at its maximum.

Top module: `pwr_startup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `state_code` is 0 and `master_en`, `contactor_on`, `bms_timeout` and `ramp_frac` are all 0.
- R2: In Init (code 0), both power outputs are low. The block moves to WaitBms (code 1) at the first clock edge that sees `enable` high and `any_fault` low. Otherwise it stays in Init.
- R3: In WaitBms, a clock edge that sees `enable` low or `any_fault` high moves the block to Fault (code 7). An edge that sees `bms_link` high with `bms_alarm` low moves it to Precharge (code 2). An edge that sees the link with the alarm also high leaves it in WaitBms.
- R4: If no exit is taken, WaitBms lasts BMS_WAIT_CYCLES+2 cycles and then moves to Fault, setting `bms_timeout`. A valid link seen at that same final edge takes priority, so the block enters Precharge and the flag stays low.
- R5: `bms_timeout` stays high through Fault and Init. It clears on the edge that moves the block from Init into WaitBms.
- R6: Precharge keeps the contactor open and the master enable low for PRECHARGE_CYCLES cycles, then moves to SoftStart (code 3). A fault or a loss of enable during Precharge moves the block to Fault.
- R7: SoftStart closes the contactor and raises the master enable. In its t-th cycle (t counted from 0), `ramp_frac` equals floor(t*(2^FRAC_W-1)/SOFTSTART_CYCLES). After SOFTSTART_CYCLES cycles it moves to Running (code 4), where `ramp_frac` is all ones. A fault or a loss of enable during SoftStart moves the block to Fault.
- R8: In Running, `derate_req` moves the block to Derate (code 6), and it returns to Running when the request clears. Both states keep `master_en` and `contactor_on` high.
- R9: Running moves to Standby (code 5) at an edge that sees `standby_req` high, once the block has been in Running for at least FLOAT_DELAY_CYCLES cycles. Standby holds the contactor closed and the master enable low. It returns to Running when `standby_req` is low.
- R10: Running, Derate and Standby move to Shutdown (code 8) on `shutdown_req` or on `enable` low. Shutdown drives both power outputs low and lasts exactly one cycle before Init.
- R11: Fault drives both power outputs low. It stays in Fault until an edge sees `enable` low and `any_fault` low, then moves to Init. In Running, Derate and Standby a fault takes priority over shutdown.
- R12: `state_code` is always in 0..8. A held code of 9..15 moves the block to Fault at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Operator run command |
| any_fault | input | 1 | Aggregated hard-fault flag |
| bms_link | input | 1 | Battery management reports connected |
| bms_alarm | input | 1 | Battery management reports a fault |
| derate_req | input | 1 | Soft-fault request for reduced power |
| standby_req | input | 1 | Request to idle in float |
| shutdown_req | input | 1 | Request for orderly shutdown |
| master_en | output | 1 | Converter master enable |
| contactor_on | output | 1 | Main contactor close command |
| state_code | output | 4 | Current state encoding |
| bms_timeout | output | 1 | Sticky battery-management timeout flag |
| ramp_frac | output | FRAC_W | Soft-start reference fraction |

## Verification
Two events can land on the same edge: the arrival of a valid battery link and the expiry of the WaitBms wait. The bench raises the link exactly at the deciding edge. It then expects Precharge with the timeout flag low, and separately confirms that leaving the link low at that edge gives Fault with the flag set. A second coincidence, a fault together with a shutdown request while running, is provoked with both inputs raised for one edge and must end in Fault, not Shutdown.

// File: rtl/pwr_startup_seq.sv
module pwr_startup_seq #(
  parameter int unsigned BMS_WAIT_CYCLES    = 100_000_000,
  parameter int unsigned PRECHARGE_CYCLES   = 1000,
  parameter int unsigned SOFTSTART_CYCLES   = 100_000,
  parameter int unsigned FLOAT_DELAY_CYCLES = 1_000_000,
  parameter int unsigned TIMER_W            = 32,
  parameter int unsigned FRAC_W             = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              any_fault,
  input  logic              bms_link,
  input  logic              bms_alarm,
  input  logic              derate_req,
  input  logic              standby_req,
  input  logic              shutdown_req,
  output logic              master_en,
  output logic              contactor_on,
  output logic [3:0]        state_code,
  output logic              bms_timeout,
  output logic [FRAC_W-1:0] ramp_frac
);

  typedef enum logic [3:0] {
    S_INIT = 4'd0, S_WAIT = 4'd1, S_PRE = 4'd2, S_SOFT = 4'd3, S_RUN = 4'd4,
    S_STBY = 4'd5, S_DER = 4'd6, S_FLT = 4'd7, S_SHUT = 4'd8
  } st_t;

  localparam int unsigned PW = TIMER_W + FRAC_W;
  localparam int unsigned FULL = (2 ** FRAC_W) - 1;
  localparam logic [TIMER_W-1:0] WAIT_LIM  = TIMER_W'(BMS_WAIT_CYCLES);
  localparam logic [TIMER_W-1:0] PRE_LAST  = TIMER_W'(PRECHARGE_CYCLES - 1);
  localparam logic [TIMER_W-1:0] SOFT_LAST = TIMER_W'(SOFTSTART_CYCLES - 1);
  localparam logic [TIMER_W-1:0] FLOAT_MIN = TIMER_W'(FLOAT_DELAY_CYCLES);

  st_t state, nxt;
  logic [TIMER_W-1:0] timer;
  logic [PW-1:0] prod;
  logic [FRAC_W-1:0] ramp_soft;
  logic link_ok, go_on, wait_expired;

  assign link_ok = bms_link && !bms_alarm;
  assign go_on = enable && !any_fault;
  assign wait_expired = (state == S_WAIT) && go_on && !link_ok && (timer > WAIT_LIM);

  always_comb begin
    nxt = state;
    case (state)
      S_INIT: if (go_on) nxt = S_WAIT;
      S_WAIT: begin
        if (!go_on) nxt = S_FLT;
        else if (link_ok) nxt = S_PRE;
        else if (timer > WAIT_LIM) nxt = S_FLT;
      end
      S_PRE: begin
        if (!go_on) nxt = S_FLT;
        else if (timer == PRE_LAST) nxt = S_SOFT;
      end
      S_SOFT: begin
        if (!go_on) nxt = S_FLT;
        else if (timer == SOFT_LAST) nxt = S_RUN;
      end
      S_RUN: begin
        if (any_fault) nxt = S_FLT;
        else if (!enable || shutdown_req) nxt = S_SHUT;
        else if (derate_req) nxt = S_DER;
        else if (standby_req && timer >= FLOAT_MIN) nxt = S_STBY;
      end
      S_DER: begin
        if (any_fault) nxt = S_FLT;
        else if (!enable || shutdown_req) nxt = S_SHUT;
        else if (!derate_req) nxt = S_RUN;
      end
      S_STBY: begin
        if (any_fault) nxt = S_FLT;
        else if (!enable || shutdown_req) nxt = S_SHUT;
        else if (!standby_req) nxt = S_RUN;
      end
      S_FLT: if (!enable && !any_fault) nxt = S_INIT;
      S_SHUT: nxt = S_INIT;
      default: nxt = S_FLT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_INIT;
      timer <= '0;
      bms_timeout <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) timer <= '0;
      else if (timer != {TIMER_W{1'b1}}) timer <= timer + 1'b1;
      if (state == S_INIT && nxt == S_WAIT) bms_timeout <= 1'b0;
      else if (wait_expired) bms_timeout <= 1'b1;
    end
  end

  assign prod = PW'(timer) * PW'(FULL);
  assign ramp_soft = FRAC_W'(prod / PW'(SOFTSTART_CYCLES));

  assign master_en = (state == S_SOFT) || (state == S_RUN) || (state == S_DER);
  assign contactor_on = master_en || (state == S_STBY);
  assign state_code = state;
  assign ramp_frac = (state == S_SOFT) ? ramp_soft :
                     ((state == S_RUN) || (state == S_DER) || (state == S_STBY)) ? {FRAC_W{1'b1}} :
                     '0;

endmodule

module pwr_startup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       any_fault,
  input logic       derate_req,
  input logic       shutdown_req,
  input logic [3:0] state_code,
  input logic       master_en,
  input logic       contactor_on,
  input logic       bms_timeout
);

  a_r1_init_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_code == 4'd0 && !master_en && !contactor_on && !bms_timeout));

  a_r12_code_range: assert property (@(posedge clk) disable iff (rst)
    state_code <= 4'd8);

  a_r7_enable_needs_contactor: assert property (@(posedge clk) disable iff (rst)
    master_en |-> contactor_on);

  a_r3_wait_abort: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd1 && (!enable || any_fault)) |=> state_code == 4'd7);

  a_r4_timeout_into_fault: assert property (@(posedge clk) disable iff (rst)
    $rose(bms_timeout) |-> (state_code == 4'd7 && $past(state_code) == 4'd1));

  a_r5_timeout_clear_on_exit_init: assert property (@(posedge clk) disable iff (rst)
    $fell(bms_timeout) |-> (state_code == 4'd1 && $past(state_code) == 4'd0));

  a_r8_derate_entry: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd4 && enable && !any_fault && !shutdown_req && derate_req) |=> state_code == 4'd6);

  a_r10_shutdown_single_cycle: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd8 |=> state_code == 4'd0);

  a_r11_fault_hold: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd7 && (enable || any_fault)) |=> state_code == 4'd7);

endmodule

bind pwr_startup_seq pwr_startup_seq_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .any_fault(any_fault),
  .derate_req(derate_req), .shutdown_req(shutdown_req), .state_code(state_code),
  .master_en(master_en), .contactor_on(contactor_on), .bms_timeout(bms_timeout)
);

// File: tb/pwr_startup_seq_bench.sv
module pwr_startup_seq_bench;
  localparam int WAITC = 20;
  localparam int PREC = 4;
  localparam int SOFTC = 5;
  localparam int FLOATC = 3;

  localparam logic [6:0] EN = 7'b1000000;
  localparam logic [6:0] FL = 7'b0100000;
  localparam logic [6:0] CO = 7'b0010000;
  localparam logic [6:0] BF = 7'b0001000;
  localparam logic [6:0] SO = 7'b0000100;
  localparam logic [6:0] SB = 7'b0000010;
  localparam logic [6:0] SH = 7'b0000001;
  localparam logic [6:0] NO = 7'b0000000;

  localparam int NROWS = 40;
  localparam logic [20:0] TBL [NROWS] = '{
    {NO, 4'd0, 1'b0, 1'b0, 8'd0},
    {EN|FL, 4'd0, 1'b0, 1'b0, 8'd0},
    {EN, 4'd1, 1'b0, 1'b0, 8'd0},
    {EN|CO|BF, 4'd1, 1'b0, 1'b0, 8'd0},
    {EN|CO, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd3, 1'b1, 1'b1, 8'd0},
    {EN, 4'd3, 1'b1, 1'b1, 8'd51},
    {EN, 4'd3, 1'b1, 1'b1, 8'd102},
    {EN, 4'd3, 1'b1, 1'b1, 8'd153},
    {EN, 4'd3, 1'b1, 1'b1, 8'd204},
    {EN, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SB, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SB, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SB, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SB, 4'd5, 1'b0, 1'b1, 8'd255},
    {EN|SB, 4'd5, 1'b0, 1'b1, 8'd255},
    {EN, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SO, 4'd6, 1'b1, 1'b1, 8'd255},
    {EN|SO, 4'd6, 1'b1, 1'b1, 8'd255},
    {EN, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SO|FL, 4'd7, 1'b0, 1'b0, 8'd0},
    {FL, 4'd7, 1'b0, 1'b0, 8'd0},
    {EN, 4'd7, 1'b0, 1'b0, 8'd0},
    {NO, 4'd0, 1'b0, 1'b0, 8'd0},
    {EN, 4'd1, 1'b0, 1'b0, 8'd0},
    {EN|CO, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd2, 1'b0, 1'b0, 8'd0},
    {EN, 4'd3, 1'b1, 1'b1, 8'd0},
    {EN, 4'd3, 1'b1, 1'b1, 8'd51},
    {EN, 4'd3, 1'b1, 1'b1, 8'd102},
    {EN, 4'd3, 1'b1, 1'b1, 8'd153},
    {EN, 4'd3, 1'b1, 1'b1, 8'd204},
    {EN, 4'd4, 1'b1, 1'b1, 8'd255},
    {EN|SH, 4'd8, 1'b0, 1'b0, 8'd0},
    {EN, 4'd0, 1'b0, 1'b0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, any_fault = 1'b0, bms_link = 1'b0, bms_alarm = 1'b0;
  logic derate_req = 1'b0, standby_req = 1'b0, shutdown_req = 1'b0;
  logic master_en, contactor_on, bms_timeout;
  logic [3:0] state_code;
  logic [7:0] ramp_frac;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_startup_seq #(
    .BMS_WAIT_CYCLES(WAITC), .PRECHARGE_CYCLES(PREC),
    .SOFTSTART_CYCLES(SOFTC), .FLOAT_DELAY_CYCLES(FLOATC),
    .TIMER_W(32), .FRAC_W(8)
  ) u_pwr_startup_seq (
    .clk(clk), .rst(rst), .enable(enable), .any_fault(any_fault),
    .bms_link(bms_link), .bms_alarm(bms_alarm), .derate_req(derate_req),
    .standby_req(standby_req), .shutdown_req(shutdown_req),
    .master_en(master_en), .contactor_on(contactor_on), .state_code(state_code),
    .bms_timeout(bms_timeout), .ramp_frac(ramp_frac)
  );

  task automatic check_now(input logic [3:0] es, input logic eme, input logic ecc,
                           input logic [7:0] ef, input logic eto, input string tag);
    checks++;
    if (state_code !== es || master_en !== eme || contactor_on !== ecc ||
        ramp_frac !== ef || bms_timeout !== eto) begin
      errors++;
      $display("FAIL %s: got state=%0d me=%0b cc=%0b frac=%0d to=%0b expected state=%0d me=%0b cc=%0b frac=%0d to=%0b",
               tag, state_code, master_en, contactor_on, ramp_frac, bms_timeout,
               es, eme, ecc, ef, eto);
    end
  endtask

  task automatic step(input logic [6:0] iv, input logic [3:0] es, input logic eme,
                      input logic ecc, input logic [7:0] ef, input logic eto, input string tag);
    {enable, any_fault, bms_link, bms_alarm, derate_req, standby_req, shutdown_req} = iv;
    @(negedge clk);
    check_now(es, eme, ecc, ef, eto, tag);
  endtask

  task automatic bring_up(input string tag);
    step(EN, 4'd1, 1'b0, 1'b0, 8'd0, 1'b0, tag);
    step(EN|CO, 4'd2, 1'b0, 1'b0, 8'd0, 1'b0, tag);
    for (int i = 0; i < PREC - 1; i++) step(EN, 4'd2, 1'b0, 1'b0, 8'd0, 1'b0, tag);
    for (int t = 0; t < SOFTC; t++) step(EN, 4'd3, 1'b1, 1'b1, 8'((t * 255) / SOFTC), 1'b0, tag);
    step(EN, 4'd4, 1'b1, 1'b1, 8'd255, 1'b0, tag);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (state_code > 4'd8) begin
        errors++;
        $display("FAIL R12: state code %0d expected at most 8", state_code);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active after 20000 cycles, expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R1 during reset");
    rst = 1'b0;
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R1 after reset");

    for (int r = 0; r < NROWS; r++) begin
      logic [20:0] row;
      row = TBL[r];
      step(row[20:14], row[13:10], row[9], row[8], row[7:0], 1'b0,
           $sformatf("table row %0d (R2 R3 R6 R7 R8 R9 R10 R11)", r));
    end

    step(EN, 4'd1, 1'b0, 1'b0, 8'd0, 1'b0, "R3 enter wait");
    step(NO, 4'd7, 1'b0, 1'b0, 8'd0, 1'b0, "R3 enable loss in wait");
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R11 fault release");

    step(EN, 4'd1, 1'b0, 1'b0, 8'd0, 1'b0, "R4 enter wait");
    for (int i = 0; i < WAITC + 1; i++) step(EN, 4'd1, 1'b0, 1'b0, 8'd0, 1'b0, "R4 wait dwell");
    step(EN, 4'd7, 1'b0, 1'b0, 8'd0, 1'b1, "R4 timeout into fault");
    step(EN, 4'd7, 1'b0, 1'b0, 8'd0, 1'b1, "R11 hold with enable high");
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b1, "R5 flag kept in init");
    step(EN, 4'd1, 1'b0, 1'b0, 8'd0, 1'b0, "R5 flag cleared leaving init");

    for (int i = 0; i < WAITC + 1; i++) step(EN, 4'd1, 1'b0, 1'b0, 8'd0, 1'b0, "R4 boundary dwell");
    step(EN|CO, 4'd2, 1'b0, 1'b0, 8'd0, 1'b0, "R4 link on deciding edge wins");
    step(EN, 4'd2, 1'b0, 1'b0, 8'd0, 1'b0, "R6 precharge");
    step(EN|FL, 4'd7, 1'b0, 1'b0, 8'd0, 1'b0, "R6 fault aborts precharge");
    step(EN, 4'd7, 1'b0, 1'b0, 8'd0, 1'b0, "R11 fault held enable high");
    step(FL, 4'd7, 1'b0, 1'b0, 8'd0, 1'b0, "R11 fault held fault high");
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R11 fault release");

    bring_up("R7 bring-up");
    for (int i = 0; i < FLOATC; i++) step(EN|SB, 4'd4, 1'b1, 1'b1, 8'd255, 1'b0, "R9 float delay");
    step(EN|SB, 4'd5, 1'b0, 1'b1, 8'd255, 1'b0, "R9 standby entry");
    step(EN|SB|SH, 4'd8, 1'b0, 1'b0, 8'd0, 1'b0, "R10 shutdown from standby");
    step(EN, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R10 shutdown lasts one cycle");
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R2 idle");

    bring_up("R7 bring-up");
    step(EN|SO, 4'd6, 1'b1, 1'b1, 8'd255, 1'b0, "R8 derate entry");
    step(SO, 4'd8, 1'b0, 1'b0, 8'd0, 1'b0, "R10 enable loss in derate");
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R10 back to init");

    bring_up("R7 bring-up");
    step(EN|FL|SH, 4'd7, 1'b0, 1'b0, 8'd0, 1'b0, "R11 fault beats shutdown");
    step(NO, 4'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R11 fault release");

    finish_up();
  end
endmodule